// File: doc/BRIEF.md
# Multi-rate e-link payload serializer

This block distributes the 80-bit user payload of each frame over a set of narrow serial lanes and shifts every lane out at one of three rates. The lane count that carries data depends on the rate: 40 lanes at 2 bits per frame (80 Mb/s), 20 lanes at 4 bits per frame (160 Mb/s), or 10 lanes at 8 bits per frame (320 Mb/s). The payload is handled as five 16-bit groups of eight lane positions each. A lane position keeps its place in every rate, so a lane at the higher rates takes the neighbouring bits of the lanes that go idle. A separate 2-bit slow-control field travels on its own lane at the lowest rate.

The block runs on a single clock with a bit-tick enable at eight ticks per 40 MHz frame, so a tick stands for one 320 Mb/s bit slot. A frame is loaded on a tick that carries the frame strobe. From then on every lane presents its bits MSB first, and each bit stays on the lane for as many ticks as its rate calls for. The rate mode is taken only when a frame is loaded.

Top module: `elink_serializer`

## Requirements
- R1: After reset, and until the first frame is loaded, every bit of `link_o` and `sc_o` is low.
- R2: A frame is loaded on a clock edge where `frame_strobe_i` and `bit_en_i` are both high. The first bit of every lane is on the outputs right after that edge. A strobe while `bit_en_i` is low is ignored.
- R3: Mode code 2'b00 (slow, 2 bits per lane per frame). Lane L carries `frame_data_i[2L+1]` and then `frame_data_i[2L]`, each for 4 ticks. Code 2'b11 behaves the same way.
- R4: Mode code 2'b01 (4 bits per lane per frame). An even lane L carries `frame_data_i[2L+3:2L]` MSB first, each bit for 2 ticks. Odd lanes stay low.
- R5: Mode code 2'b10 (8 bits per lane per frame). A lane L with L a multiple of 4 carries `frame_data_i[2L+7:2L]` MSB first, one bit per tick. All other lanes stay low.
- R6: In every mode, `sc_o` carries `sc_data_i[1]` for ticks 0 to 3 of the frame and `sc_data_i[0]` for ticks 4 to 7.
- R7: The mode is sampled only at a frame load. Changes on `mode_i`, `frame_data_i` or `sc_data_i` between loads do not affect the frame being sent.
- R8: Outputs change only on edges where `bit_en_i` is high. Cycles with `bit_en_i` low hold every output.
- R9: A new load before eight ticks have passed restarts every lane at its first bit. Once a lane's bits are all sent, it drives low until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-slot tick enable (8 per frame) |
| frame_strobe_i | input | 1 | Marks the tick that starts a frame |
| mode_i | input | 2 | Rate code: 00 slow, 01 medium, 10 fast, 11 as 00 |
| frame_data_i | input | 80 | Frame payload, lane L starting at bit 2L |
| sc_data_i | input | 2 | Slow-control field of the frame |
| link_o | output | 40 | Serial lane outputs, bit L is lane L |
| sc_o | output | 1 | Slow-control serial output |

## Verification
Every output is registered, so a loaded frame shows its tick-0 bits one clock after the load edge, and tick t shows one clock after the t-th following enabled edge. The bench drives inputs on the falling edge and compares on the next falling edge. This puts each comparison exactly one register after the edge that caused it. For idle cycles the bench compares against the previous tick's value. Between loads the mode, payload and slow-control inputs are scrambled, and the bench still expects the latched frame.

// File: rtl/elink_pkg.sv
package elink_pkg;
  localparam int unsigned WORD_W      = 8;
  localparam int unsigned FRAME_TICKS = 8;
  localparam int unsigned PHASE_W     = $clog2(FRAME_TICKS);

  typedef enum logic [1:0] {
    MODE_X2 = 2'b00,
    MODE_X4 = 2'b01,
    MODE_X8 = 2'b10
  } rate_mode_e;

  function automatic rate_mode_e decode_mode(logic [1:0] raw);
    case (raw)
      2'b01:   return MODE_X4;
      2'b10:   return MODE_X8;
      default: return MODE_X2;
    endcase
  endfunction
endpackage

// File: rtl/elink_phase_gen.sv
module elink_phase_gen
  import elink_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic               load_i,
  input  rate_mode_e         mode_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               lane_shift_o,
  output logic               sc_shift_o
);
  logic [PHASE_W-1:0] phase_q, phase_nx;
  logic               step_hit, adv;

  assign phase_nx = phase_q + 1'b1;
  assign adv      = bit_en_i & ~load_i;

  always_comb begin
    case (mode_i)
      MODE_X8: step_hit = 1'b1;
      MODE_X4: step_hit = (phase_nx[0] == 1'b0);
      default: step_hit = (phase_nx[1:0] == 2'b00);
    endcase
  end

  assign lane_shift_o = adv & step_hit;
  assign sc_shift_o   = adv & (phase_nx[1:0] == 2'b00);
  assign phase_o      = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= '0;
    else if (load_i)   phase_q <= '0;
    else if (bit_en_i) phase_q <= phase_nx;
  end
endmodule

// File: rtl/elink_lane.sv
module elink_lane
  import elink_pkg::*;
#(
  parameter int unsigned LANE_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  rate_mode_e        mode_i,
  input  logic [WORD_W-1:0] slice_i,
  output logic              bit_o
);
  localparam int unsigned W_SLOW = WORD_W / 4;
  localparam int unsigned W_MED  = WORD_W / 2;
  localparam bit          ACT_MED  = (LANE_IDX % 2) == 0;
  localparam bit          ACT_FAST = (LANE_IDX % 4) == 0;

  logic [WORD_W-1:0] ld_word, sr_q;

  // left-align so the first bit to send sits at the MSB
  always_comb begin
    case (mode_i)
      MODE_X8: ld_word = ACT_FAST ? slice_i : '0;
      MODE_X4: ld_word = ACT_MED ? {slice_i[W_MED-1:0], {(WORD_W-W_MED){1'b0}}} : '0;
      default: ld_word = {slice_i[W_SLOW-1:0], {(WORD_W-W_SLOW){1'b0}}};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= ld_word;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], 1'b0};
  end

  assign bit_o = sr_q[WORD_W-1];
endmodule

// File: rtl/elink_serializer.sv
module elink_serializer
  import elink_pkg::*;
#(
  parameter int unsigned N_LINKS = 40  // multiple of 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_en_i,
  input  logic                 frame_strobe_i,
  input  logic [1:0]           mode_i,
  input  logic [2*N_LINKS-1:0] frame_data_i,
  input  logic [1:0]           sc_data_i,
  output logic [N_LINKS-1:0]   link_o,
  output logic                 sc_o
);
  localparam int unsigned DATA_W = 2 * N_LINKS;
  localparam int unsigned PAD_W  = DATA_W + WORD_W - 2;

  logic               load;
  rate_mode_e         mode_in, mode_q;
  logic [PHASE_W-1:0] phase_w;
  logic               lane_shift, sc_shift;
  logic [PAD_W-1:0]   data_pad;
  logic [1:0]         sc_q;

  assign load     = frame_strobe_i & bit_en_i;
  assign mode_in  = decode_mode(mode_i);
  assign data_pad = {{(WORD_W-2){1'b0}}, frame_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= MODE_X2;
    else if (load) mode_q <= mode_in;
  end

  elink_phase_gen u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_en_i     (bit_en_i),
    .load_i       (load),
    .mode_i       (mode_q),
    .phase_o      (phase_w),
    .lane_shift_o (lane_shift),
    .sc_shift_o   (sc_shift)
  );

  for (genvar i = 0; i < N_LINKS; i++) begin : g_lane
    elink_lane #(.LANE_IDX(i)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .shift_i (lane_shift),
      .mode_i  (mode_in),
      .slice_i (data_pad[2*i +: WORD_W]),
      .bit_o   (link_o[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sc_q <= '0;
    else if (load)     sc_q <= sc_data_i;
    else if (sc_shift) sc_q <= {sc_q[0], 1'b0};
  end

  assign sc_o = sc_q[1];
endmodule

// File: rtl/elink_serializer_chk.sv
module elink_serializer_chk
  import elink_pkg::*;
#(
  parameter int unsigned N_LINKS = 40
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bit_en_i,
  input logic               frame_strobe_i,
  input logic [N_LINKS-1:0] link_o,
  input logic               sc_o,
  input logic [1:0]         mode_q_i,
  input logic [PHASE_W-1:0] phase_i
);
  logic               load;
  logic [N_LINKS-1:0] odd_mask, non4_mask;

  assign load = frame_strobe_i & bit_en_i;

  for (genvar i = 0; i < N_LINKS; i++) begin : g_mask
    assign odd_mask[i]  = (i % 2) != 0;
    assign non4_mask[i] = (i % 4) != 0;
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(link_o) && $stable(sc_o)));

  p_mode_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(mode_q_i));

  p_x2_cadence_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !load && mode_q_i == MODE_X2 && phase_i[1:0] != 2'b11) |=> $stable(link_o));

  p_x4_cadence_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !load && mode_q_i == MODE_X4 && phase_i[0] == 1'b0) |=> $stable(link_o));

  p_idle_odd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q_i == MODE_X4) |-> ((link_o & odd_mask) == '0));

  p_idle_lanes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q_i == MODE_X8) |-> ((link_o & non4_mask) == '0));

  p_sc_cadence_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !load && phase_i[1:0] != 2'b11) |=> $stable(sc_o));
endmodule

bind elink_serializer elink_serializer_chk #(.N_LINKS(N_LINKS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bit_en_i       (bit_en_i),
  .frame_strobe_i (frame_strobe_i),
  .link_o         (link_o),
  .sc_o           (sc_o),
  .mode_q_i       (mode_q),
  .phase_i        (phase_w)
);

// File: tb/elink_serializer_tb.sv
module elink_serializer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_en_i = 1'b0;
  logic        frame_strobe_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [79:0] frame_data_i = '0;
  logic [1:0]  sc_data_i = 2'b00;
  logic [39:0] link_o;
  logic        sc_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  elink_serializer u_dut (
    .clk_i, .rst_ni, .bit_en_i, .frame_strobe_i, .mode_i,
    .frame_data_i, .sc_data_i, .link_o, .sc_o
  );

  function automatic logic [79:0] rand80();
    return {$urandom, $urandom, 16'($urandom)};
  endfunction

  function automatic logic [39:0] exp_links(logic [79:0] d, logic [1:0] m, int t);
    logic [39:0] e = '0;
    int step = (m == 2'b10) ? 1 : (m == 2'b01) ? 2 : 4;
    int width = 8 / step;
    int k = t / step;
    for (int l = 0; l < 40; l++)
      if ((l % (width / 2)) == 0 && k < width) e[l] = d[2*l + width - 1 - k];
    return e;
  endfunction

  function automatic logic exp_sc(logic [1:0] s, int t);
    if (t >= 8) return 1'b0;
    return (t < 4) ? s[1] : s[0];
  endfunction

  task automatic chk(logic [79:0] d, logic [1:0] s, logic [1:0] m, int t, string tag);
    logic [1:0]  dm = (m == 2'b11) ? 2'b00 : m;
    logic [39:0] e = exp_links(d, dm, t);
    logic        es = exp_sc(s, t);
    string       rq = (dm == 2'b10) ? "R5" : (dm == 2'b01) ? "R4" : "R3";
    n_chk += 2;
    if (link_o !== e) begin
      n_bad++;
      $display("FAIL %s %s tick %0d link_o=%h expected=%h", rq, tag, t, link_o, e);
    end
    if (sc_o !== es) begin
      n_bad++;
      $display("FAIL R6 %s tick %0d sc_o=%b expected=%b", tag, t, sc_o, es);
    end
  endtask

  task automatic chk_zero(string tag);
    n_chk++;
    if (link_o !== '0 || sc_o !== 1'b0) begin
      n_bad++;
      $display("FAIL %s link_o=%h sc_o=%b expected=0 0", tag, link_o, sc_o);
    end
  endtask

  // drives at a falling edge, compares on the next falling edge
  task automatic do_frame(logic [79:0] d, logic [1:0] s, logic [1:0] m, int n_ticks, bit gaps, string tag);
    frame_data_i = d; sc_data_i = s; mode_i = m;
    frame_strobe_i = 1'b1; bit_en_i = 1'b1;
    @(negedge clk_i);
    chk(d, s, m, 0, {tag, " R2"});
    for (int t = 1; t < n_ticks; t++) begin
      frame_strobe_i = 1'b0;
      mode_i = 2'($urandom);   // R7 noise between loads
      frame_data_i = rand80();
      sc_data_i = 2'($urandom);
      if (gaps && ($urandom % 3) == 0) begin
        bit_en_i = 1'b0;
        frame_strobe_i = 1'($urandom);
        @(negedge clk_i);
        chk(d, s, m, t - 1, "R8 R2 idle");
        frame_strobe_i = 1'b0;
      end
      bit_en_i = 1'b1;
      @(negedge clk_i);
      chk(d, s, m, t, {tag, " R7"});
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_e11c));
    repeat (3) @(negedge clk_i);
    chk_zero("R1 in reset");
    rst_ni = 1'b1;
    bit_en_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk_zero("R1 before first frame");
    end
    // strobe without tick is ignored
    bit_en_i = 1'b0; frame_strobe_i = 1'b1; frame_data_i = '1; sc_data_i = 2'b11; mode_i = 2'b10;
    @(negedge clk_i);
    chk_zero("R2 strobe without tick");
    @(negedge clk_i);
    chk_zero("R2 strobe without tick");

    do_frame({5{16'hA5C3}}, 2'b10, 2'b00, 8, 1'b0, "R3 slow");
    do_frame(80'h0123_4567_89AB_CDEF_F00D, 2'b01, 2'b01, 8, 1'b0, "R4 medium");
    do_frame(80'hFEDC_BA98_7654_3210_BEEF, 2'b11, 2'b10, 8, 1'b0, "R5 fast");
    do_frame({40{2'b10}}, 2'b01, 2'b11, 8, 1'b0, "R3 code 11");
    do_frame('1, 2'b11, 2'b10, 8, 1'b0, "R5 ones");
    // abort and run-out
    do_frame(rand80(), 2'b10, 2'b01, 3, 1'b0, "R9 aborted");
    do_frame(rand80(), 2'b01, 2'b00, 5, 1'b1, "R9 aborted");
    do_frame(rand80(), 2'b11, 2'b10, 12, 1'b0, "R9 run-out");
    do_frame(rand80(), 2'b10, 2'b00, 12, 1'b1, "R9 run-out");

    for (int f = 0; f < 80; f++) begin
      int nt = (($urandom % 8) == 0) ? int'(1 + $urandom % 11) : 8;
      do_frame(rand80(), 2'($urandom), 2'($urandom), nt, 1'($urandom), "R9 random");
    end

    bit_en_i = 1'b1; frame_strobe_i = 1'b0;
    for (int i = 0; i < 9; i++) @(negedge clk_i);
    chk_zero("R9 idle after frame");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule